// File: doc/BRIEF.md
# Per-Branch History Direction Predictor

This block guesses whether a conditional branch will be taken by looking at how that same branch behaved on its recent executions. A small table of shift registers holds one outcome history per branch slot, and the slot is picked by low-order bits of the branch address. The history read from the chosen slot then addresses a shared table of 2-bit saturating counters, and the upper bit of the addressed counter is the guess.

A fetch stage presents an address on the lookup port and reads back the guess, together with the history and counter value behind it. When the branch resolves, the back end presents the same address and the real direction on the training port. The counter selected by the history the slot held before training is moved one step toward that direction. The direction is then shifted into the slot's history. Lookup is combinational, and all state changes on the rising clock edge.

Top module: `local_hist_pred`

## Requirements
- R1: After reset every history slot reads 0 and every counter reads 2'b01 (weakly not taken), so every lookup returns not taken.
- R2: The history slot is chosen by PC bits [ALIGN_BITS +: log2(SLOTS)] (bits [5:2] by default). PC bits below and above that field have no effect on which slot is used.
- R3: A training event shifts the slot's history left by one. The real direction (1 = taken) enters at bit 0 and the oldest bit, bit HIST_W-1, is dropped.
- R4: The counter trained is the one addressed by the slot's history as it was before the shift in the same event.
- R5: A taken outcome increments that counter and a not-taken outcome decrements it. The counter saturates at 3 and at 0.
- R6: The lookup guess is taken exactly when bit 1 of the addressed counter is 1.
- R7: A training event changes only the history of its own slot. Lookups to other slots return unchanged histories.
- R8: The counter table is shared. Branches in different slots that hold the same history read the same counter, including changes made by another slot's training.
- R9: A lookup in the same cycle as a training event to the same slot returns the values from before the training. The trained values appear from the next cycle on.
- R10: When upd_valid is 0, the upd_pc and upd_taken inputs change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Guess: 1 = taken |
| lk_hist | output | HIST_W | History held by the slot selected for the lookup |
| lk_ctr | output | 2 | Counter value addressed by that history |
| upd_valid | input | 1 | Training event this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real direction of the resolved branch, 1 = taken |

## Verification
A bad shift, or a write to the wrong slot, shows up on lk_hist at the first lookup of an affected address in the cycle after the training edge. A counter trained at the post-shift history instead of the pre-shift one leaves the counter that should have moved unchanged. The bench exposes this by looking up a second branch that holds the old history. A wrong saturation bound shows as a counter value of 0 after a run of taken outcomes, or a value of 3 after a run of not-taken outcomes, and the guess flips at the step where it happens. Updates that leak while upd_valid is 0 appear on lk_hist of the touched slot one cycle later.

// File: rtl/local_hist_pred.sv
module local_hist_pred #(
  parameter int PC_W       = 32,
  parameter int ALIGN_BITS = 2,
  parameter int SLOTS      = 16,
  parameter int HIST_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic [HIST_W-1:0] lk_hist,
  output logic [1:0]        lk_ctr,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken
);
  localparam int IDX_W = $clog2(SLOTS);
  localparam int CTRS  = 1 << HIST_W;

  logic [HIST_W-1:0] hist_q [SLOTS];
  logic [1:0]        ctr_q  [CTRS];

  logic [IDX_W-1:0]  l_idx, u_idx;
  logic [HIST_W-1:0] u_hist;
  logic [1:0]        u_ctr, u_ctr_nx;

  assign l_idx    = lk_pc[ALIGN_BITS +: IDX_W];
  assign u_idx    = upd_pc[ALIGN_BITS +: IDX_W];
  assign lk_hist  = hist_q[l_idx];
  assign lk_ctr   = ctr_q[lk_hist];
  assign lk_taken = lk_ctr[1];
  assign u_hist   = hist_q[u_idx];
  assign u_ctr    = ctr_q[u_hist];

  always_comb begin
    u_ctr_nx = u_ctr;
    if (upd_taken && u_ctr != 2'd3) u_ctr_nx = u_ctr + 2'd1;
    else if (!upd_taken && u_ctr != 2'd0) u_ctr_nx = u_ctr - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) hist_q[i] <= '0;
    end else if (upd_valid) begin
      hist_q[u_idx] <= {u_hist[HIST_W-2:0], upd_taken};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CTRS; i++) ctr_q[i] <= 2'b01;
    end else if (upd_valid) begin
      ctr_q[u_hist] <= u_ctr_nx;
    end
  end

  assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lk_hist == '0 && lk_ctr == 2'b01));

  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> hist_q[$past(u_idx)] == {$past(u_hist[HIST_W-2:0]), $past(upd_taken)});

  assert_sat_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && u_ctr == 2'd3) |=> ctr_q[$past(u_hist)] == 2'd3);

  assert_sat_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && u_ctr == 2'd0) |=> ctr_q[$past(u_hist)] == 2'd0);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> (!$stable(lk_pc) || ($stable(lk_hist) && $stable(lk_ctr))));
endmodule

// File: tb/tb_local_hist_pred.sv
module tb_local_hist_pred;
  localparam int CLK_P  = 10;
  localparam int PC_W   = 32;
  localparam int HIST_W = 6;
  localparam int SLOTS  = 16;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] lk_pc = '0, upd_pc = '0;
  logic upd_valid = 0, upd_taken = 0;
  logic lk_taken;
  logic [HIST_W-1:0] lk_hist;
  logic [1:0] lk_ctr;

  int n_chk = 0, n_bad = 0;
  logic [HIST_W-1:0] mh [SLOTS];
  logic [1:0]        mc [1 << HIST_W];

  always #(CLK_P/2) clk = ~clk;

  local_hist_pred dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_hist(lk_hist), .lk_ctr(lk_ctr), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken));

  function automatic int slot(input logic [PC_W-1:0] pc);
    return int'(pc[5:2]);
  endfunction

  task automatic model_upd(input logic [PC_W-1:0] pc, input logic t);
    int s = slot(pc);
    logic [HIST_W-1:0] h = mh[s];
    if (t && mc[h] != 2'd3) mc[h] = mc[h] + 2'd1;
    else if (!t && mc[h] != 2'd0) mc[h] = mc[h] - 2'd1;
    mh[s] = {h[HIST_W-2:0], t};
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input string req);
    logic [HIST_W-1:0] eh;
    lk_pc = pc;
    #1;
    eh = mh[slot(pc)];
    n_chk++;
    if (lk_hist !== eh || lk_ctr !== mc[eh] || lk_taken !== mc[eh][1]) begin
      n_bad++;
      $display("FAIL %s pc=%h: got hist=%b ctr=%0d pred=%b, expected hist=%b ctr=%0d pred=%b",
               req, pc, lk_hist, lk_ctr, lk_taken, eh, mc[eh], mc[eh][1]);
    end
  endtask

  task automatic train(input logic [PC_W-1:0] pc, input logic t);
    @(negedge clk);
    upd_valid = 1; upd_pc = pc; upd_taken = t;
    @(posedge clk);
    model_upd(pc, t);
    @(negedge clk);
    upd_valid = 0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < SLOTS; i++) look(32'h1000 + i*4, "R1");
  endtask

  task automatic t_shift;
    logic [7:0] pat = 8'b1011_0110;
    for (int i = 0; i < 8; i++) begin
      train(32'h0000_0004, pat[i]);
      look(32'h0000_0004, "R3/R4");
    end
  endtask

  task automatic t_sat;
    for (int i = 0; i < 10; i++) begin
      train(32'h0000_0008, 1'b1);
      look(32'h0000_0008, "R5/R6 up");
    end
    for (int i = 0; i < 10; i++) begin
      train(32'h0000_0008, 1'b0);
      look(32'h0000_0008, "R5/R6 down");
    end
  endtask

  task automatic t_index;
    train(32'hABCD_0013, 1'b1);
    look(32'h0000_0010, "R2 low bits");
    look(32'h7777_0011, "R2 high bits");
    look(32'h0000_0014, "R2 neighbour");
  endtask

  task automatic t_isolate;
    look(32'h0000_0020, "R7 before");
    train(32'h0000_0024, 1'b1);
    train(32'h0000_0024, 1'b0);
    look(32'h0000_0020, "R7 other slot");
    look(32'h0000_0024, "R7 own slot");
  endtask

  task automatic t_shared;
    train(32'h0000_0030, 1'b0);
    look(32'h0000_0034, "R4/R8 shared counter");
    look(32'h0000_0038, "R8 shared counter");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    upd_valid = 1; upd_pc = 32'h0000_003C; upd_taken = 1;
    look(32'h0000_003C, "R9 pre-update");
    @(posedge clk);
    model_upd(32'h0000_003C, 1'b1);
    @(negedge clk);
    upd_valid = 0;
    look(32'h0000_003C, "R9 post-update");
  endtask

  task automatic t_idle;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      upd_valid = 0; upd_pc = 32'h0000_003C; upd_taken = i[0];
    end
    @(negedge clk);
    look(32'h0000_003C, "R10 idle");
    look(32'h0000_0008, "R10 idle other");
  endtask

  initial begin
    for (int i = 0; i < SLOTS; i++) mh[i] = '0;
    for (int i = 0; i < (1 << HIST_W); i++) mc[i] = 2'b01;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_shift();
    t_sat();
    t_index();
    t_isolate();
    t_shared();
    t_same_cycle();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule